// File: doc/BRIEF.md
# Concurrent Auto-Precharge Spacing Monitor

This block watches the command stream of a DDR-style memory controller. Each command arrives as one decoded strobe, with a kind, a bank number and an auto-precharge flag. The block checks that a command to a different bank does not follow a read or write with auto-precharge too soon. The minimum spacing depends on two things: whether the tracked command was a read or a write, and whether the new command is a read, a write, a precharge or an activate. CAS latency, burst length and the write-to-read turnaround are supplied as configuration inputs, so one instance can serve every operating point.

Only the most recent auto-precharge column command is tracked, and any newer one replaces it. A spacing violation raises a one-cycle error pulse. When the violation pits read data against write data, a second pulse marks it as a data collision. Commands to the tracked bank itself are not checked.

Top module: `ap_spacing_mon`

## Requirements
- R1: After reset, and whenever no auto-precharge read or write has been seen since reset, both `err_early` and `err_collide` stay 0 for every command.
- R2: A read (`cmd_kind`=0) to another bank whose gap from a tracked read with auto-precharge is below `cfg_bl`/2 raises `err_early`. A gap equal to or above that value raises nothing.
- R3: A write (`cmd_kind`=1) to another bank whose gap from a tracked read with auto-precharge is below ceil(CL)+`cfg_bl`/2 raises both `err_early` and `err_collide`. A gap equal to or above that value raises nothing.
- R4: A read to another bank whose gap from a tracked write with auto-precharge is below 1+`cfg_bl`/2+`cfg_twtr` raises both `err_early` and `err_collide`. A gap equal to or above that value raises nothing.
- R5: A write to another bank whose gap from a tracked write with auto-precharge is below `cfg_bl`/2 raises `err_early` with `err_collide` left at 0. A gap equal to or above that value raises nothing.
- R6: A precharge (`cmd_kind`=2) or activate (`cmd_kind`=3) to another bank needs a gap of only 1 cycle, so it never raises an error.
- R7: A command to the same bank as the tracked command never raises an error.
- R8: Each read or write with `cmd_ap`=1 first has its own spacing checked. It then becomes the tracked command, whatever its bank. A read or write with `cmd_ap`=0 is checked but leaves the tracking unchanged.
- R9: The gap is the number of cycles from the tracked command's issue cycle to the new command's issue cycle, so a command in the next cycle has gap 1. Error flags appear in the cycle after the offending command and last exactly one cycle.
- R10: `cfg_cl_half` gives CL in half cycles (4 = 2, 5 = 2.5, 6 = 3). The R3 term rounds it up to whole cycles: 2, 3 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 read, 1 write, 2 precharge, 3 activate |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge flag for a read or write |
| cfg_cl_half | input | CLH_W | CAS latency in half cycles |
| cfg_bl | input | BL_W | Burst length in data beats |
| cfg_twtr | input | TWTR_W | Write-to-read turnaround in cycles |
| err_early | output | 1 | Pulse: the previous cycle's command broke a spacing rule |
| err_collide | output | 1 | Pulse: that violation mixes read and write data |

## Verification
Both error flags come from one register stage, so each is due exactly one cycle after the command that caused it. No flag is due on an idle cycle.

The bench drives a command on a falling edge and lets the rising edge capture it. Just after that edge it queues the flags its own model expects. A monitor pops the queue on the next falling edge and compares, so every cycle, idle ones included, is compared at that single point.

The sweep places the second command at every gap from 1 to 14 cycles after the auto-precharge command. It does this for each pairing of earlier and later command kind and for several settings of CL, burst length and turnaround. This reaches both sides of each threshold, including a gap exactly equal to the minimum.

// File: rtl/apspc_pkg.sv
package apspc_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_PRECH = 2'd2,
        CMD_ACTIV = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        logic early;
        logic collide;
    } viol_t;

    function automatic logic is_column(input cmd_kind_e k);
        return (k == CMD_READ) || (k == CMD_WRITE);
    endfunction

    // Minimum gap in cycles from a tracked auto-precharge column command
    // (prev_wr selects write or read) to a command of kind nxt elsewhere.
    function automatic int unsigned need_cycles(
        input logic        prev_wr,
        input cmd_kind_e   nxt,
        input int unsigned cl_half,
        input int unsigned bl,
        input int unsigned twtr
    );
        int unsigned half_bl;
        int unsigned cl_up;
        half_bl = bl >> 1;
        cl_up   = (cl_half + 1) >> 1;
        if (!is_column(nxt)) begin
            return 1;
        end
        if (!prev_wr) begin
            return (nxt == CMD_READ) ? half_bl : (cl_up + half_bl);
        end
        return (nxt == CMD_WRITE) ? half_bl : (1 + half_bl + twtr);
    endfunction

endpackage

// File: rtl/apspc_tracker.sv
module apspc_tracker
    import apspc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_kind_e         cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_ap,
    output logic              trk_valid,
    output logic              trk_wr,
    output logic [BANK_W-1:0] trk_bank,
    output logic [CNT_W-1:0]  trk_gap
);

    localparam logic [CNT_W-1:0] GAP_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] GAP_ONE = CNT_W'(1);

    logic reload;

    assign reload = cmd_valid && cmd_ap && is_column(cmd_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_valid <= 1'b0;
            trk_wr    <= 1'b0;
            trk_bank  <= '0;
            trk_gap   <= '0;
        end else if (reload) begin
            trk_valid <= 1'b1;
            trk_wr    <= (cmd_kind == CMD_WRITE);
            trk_bank  <= cmd_bank;
            trk_gap   <= GAP_ONE;
        end else if (trk_valid && (trk_gap != GAP_MAX)) begin
            trk_gap   <= trk_gap + GAP_ONE;
        end
    end

endmodule

// File: rtl/apspc_gap_calc.sv
module apspc_gap_calc
    import apspc_pkg::*;
#(
    parameter int CLH_W  = 3,
    parameter int BL_W   = 4,
    parameter int TWTR_W = 3,
    parameter int CNT_W  = 6
) (
    input  logic              trk_wr,
    input  cmd_kind_e         cmd_kind,
    input  logic [CLH_W-1:0]  cfg_cl_half,
    input  logic [BL_W-1:0]   cfg_bl,
    input  logic [TWTR_W-1:0] cfg_twtr,
    output logic [CNT_W-1:0]  need_gap
);

    localparam int unsigned NEED_MAX = (1 << CNT_W) - 1;

    int unsigned raw;

    always_comb begin
        raw = need_cycles(trk_wr, cmd_kind, 32'(cfg_cl_half),
                          32'(cfg_bl), 32'(cfg_twtr));
        if (raw > NEED_MAX) begin
            need_gap = {CNT_W{1'b1}};
        end else begin
            need_gap = CNT_W'(raw);
        end
    end

endmodule

// File: rtl/apspc_judge.sv
module apspc_judge
    import apspc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_kind_e         cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              trk_valid,
    input  logic              trk_wr,
    input  logic [BANK_W-1:0] trk_bank,
    input  logic [CNT_W-1:0]  trk_gap,
    input  logic [CNT_W-1:0]  need_gap,
    output viol_t             viol
);

    logic  other_bank;
    logic  too_soon;
    logic  turn_dir;
    viol_t viol_d;

    always_comb begin
        other_bank     = trk_valid && (cmd_bank != trk_bank);
        too_soon       = cmd_valid && other_bank && (trk_gap < need_gap);
        turn_dir       = is_column(cmd_kind) && ((cmd_kind == CMD_WRITE) != trk_wr);
        viol_d.early   = too_soon;
        viol_d.collide = too_soon && turn_dir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol <= '0;
        end else begin
            viol <= viol_d;
        end
    end

endmodule

// File: rtl/ap_spacing_mon.sv
module ap_spacing_mon
    import apspc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CLH_W  = 3,
    parameter int BL_W   = 4,
    parameter int TWTR_W = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_ap,
    input  logic [CLH_W-1:0]  cfg_cl_half,
    input  logic [BL_W-1:0]   cfg_bl,
    input  logic [TWTR_W-1:0] cfg_twtr,
    output logic              err_early,
    output logic              err_collide
);

    cmd_kind_e         kind;
    logic              trk_valid;
    logic              trk_wr;
    logic [BANK_W-1:0] trk_bank;
    logic [CNT_W-1:0]  trk_gap;
    logic [CNT_W-1:0]  need_gap;
    viol_t             viol;

    assign kind = cmd_kind_e'(cmd_kind);

    apspc_tracker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_kind  (kind),
        .cmd_bank  (cmd_bank),
        .cmd_ap    (cmd_ap),
        .trk_valid (trk_valid),
        .trk_wr    (trk_wr),
        .trk_bank  (trk_bank),
        .trk_gap   (trk_gap)
    );

    apspc_gap_calc #(.CLH_W(CLH_W), .BL_W(BL_W), .TWTR_W(TWTR_W), .CNT_W(CNT_W)) u_gap (
        .trk_wr      (trk_wr),
        .cmd_kind    (kind),
        .cfg_cl_half (cfg_cl_half),
        .cfg_bl      (cfg_bl),
        .cfg_twtr    (cfg_twtr),
        .need_gap    (need_gap)
    );

    apspc_judge #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_kind  (kind),
        .cmd_bank  (cmd_bank),
        .trk_valid (trk_valid),
        .trk_wr    (trk_wr),
        .trk_bank  (trk_bank),
        .trk_gap   (trk_gap),
        .need_gap  (need_gap),
        .viol      (viol)
    );

    assign err_early   = viol.early;
    assign err_collide = viol.collide;

endmodule

// File: rtl/ap_spacing_mon_props.sv
module ap_spacing_mon_props #(
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              trk_valid,
    input logic [BANK_W-1:0] trk_bank,
    input logic              err_early,
    input logic              err_collide
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!err_early && !err_collide));

    a_r1_untracked_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !trk_valid) |=> !err_early);

    a_r3_collide_needs_early: assert property (@(posedge clk) disable iff (rst)
        err_collide |-> err_early);

    a_r6_row_cmd_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind[1]) |=> (!err_early && !err_collide));

    a_r7_same_bank_quiet: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && trk_valid && (cmd_bank == trk_bank)) |=> !err_early);

    a_r9_flag_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        err_early |-> $past(cmd_valid));

endmodule

bind ap_spacing_mon ap_spacing_mon_props #(.BANK_W(BANK_W)) u_props (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .cmd_bank    (cmd_bank),
    .trk_valid   (trk_valid),
    .trk_bank    (trk_bank),
    .err_early   (err_early),
    .err_collide (err_collide)
);

// File: tb/ap_spacing_mon_test.sv
module ap_spacing_mon_test;

    localparam int BANK_W = 2;
    localparam int CLH_W  = 3;
    localparam int BL_W   = 4;
    localparam int TWTR_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = 2'd0;
    logic [BANK_W-1:0] cmd_bank = '0;
    logic              cmd_ap = 1'b0;
    logic [CLH_W-1:0]  cfg_cl_half = 3'd4;
    logic [BL_W-1:0]   cfg_bl = 4'd4;
    logic [TWTR_W-1:0] cfg_twtr = 3'd1;
    logic              err_early;
    logic              err_collide;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic  early;
        logic  collide;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    int   num = 0;
    logic m_valid = 1'b0;
    int   m_cycle = 0;
    logic m_wr = 1'b0;
    int   m_bank = 0;

    always #10 clk = ~clk;

    ap_spacing_mon uut (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_bank    (cmd_bank),
        .cmd_ap      (cmd_ap),
        .cfg_cl_half (cfg_cl_half),
        .cfg_bl      (cfg_bl),
        .cfg_twtr    (cfg_twtr),
        .err_early   (err_early),
        .err_collide (err_collide)
    );

    function automatic int need_of(input logic pw, input int k);
        int hb = int'(cfg_bl) / 2;
        int cu = (int'(cfg_cl_half) + 1) / 2;
        if (k >= 2) return 1;
        if (!pw) return (k == 0) ? hb : cu + hb;
        return (k == 1) ? hb : 1 + hb + int'(cfg_twtr);
    endfunction

    task automatic cycle(input logic v, input int k, input int b, input logic ap,
                         input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v;
        cmd_kind  = 2'(k);
        cmd_bank  = BANK_W'(b);
        cmd_ap    = ap;
        @(posedge clk);
        #1;
        num++;
        e.early = 1'b0;
        e.collide = 1'b0;
        e.tag = tag;
        if (v && m_valid && (b != m_bank)) begin
            e.early = ((num - m_cycle) < need_of(m_wr, k));
            e.collide = e.early && (k < 2) && ((k == 1) != m_wr);
        end
        if (v && ap && (k < 2)) begin
            m_valid = 1'b1;
            m_cycle = num;
            m_wr = (k == 1);
            m_bank = b;
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 0, 0, 1'b0, "R9");
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (err_early !== e.early || err_collide !== e.collide) begin
                    failures++;
                    $display("FAIL %s: early/collide actual=%b%b expected=%b%b",
                             e.tag, err_early, err_collide, e.early, e.collide);
                end
            end
        end
    end

    function automatic string tag_of(input int pk, input int k);
        if (k >= 2) return "R6";
        if (pk == 0) return (k == 0) ? "R2" : "R3/R10";
        return (k == 0) ? "R4" : "R5";
    endfunction

    initial begin : watchdog
        #(100000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        int cls[3] = '{4, 5, 6};
        int bls[3] = '{2, 4, 8};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (err_early !== 1'b0 || err_collide !== 1'b0) begin
            failures++;
            $display("FAIL R1: reset flags actual=%b%b expected=00", err_early, err_collide);
        end
        // R1: nothing tracked yet
        cycle(1'b1, 1, 1, 1'b0, "R1");
        cycle(1'b1, 0, 2, 1'b0, "R1");
        idle(2);
        // R2 R3 R4 R5 R6 R10 sweep of gaps
        for (int ci = 0; ci < 3; ci++)
            for (int bi = 0; bi < 3; bi++)
                for (int tw = 1; tw <= 2; tw++) begin
                    cfg_cl_half = 3'(cls[ci]);
                    cfg_bl = 4'(bls[bi]);
                    cfg_twtr = 3'(tw);
                    for (int pk = 0; pk < 2; pk++)
                        for (int k = 0; k < 4; k++)
                            for (int g = 1; g <= 14; g++) begin
                                cycle(1'b1, pk, 0, 1'b1, "R8");
                                idle(g - 1);
                                cycle(1'b1, k, 1, 1'b0, tag_of(pk, k));
                            end
                end
        cfg_cl_half = 3'd6;
        cfg_bl = 4'd8;
        cfg_twtr = 3'd2;
        idle(16);
        // R7: same bank right after
        cycle(1'b1, 1, 3, 1'b1, "R8");
        cycle(1'b1, 0, 3, 1'b0, "R7");
        cycle(1'b1, 0, 3, 1'b0, "R7");
        idle(16);
        // R8: newer write reload makes a read to the old bank too early
        cycle(1'b1, 0, 0, 1'b1, "R8");
        idle(4);
        cycle(1'b1, 1, 1, 1'b1, "R8");
        cycle(1'b1, 0, 0, 1'b0, "R8");
        idle(16);
        // R8: non auto-precharge write does not reload
        cycle(1'b1, 0, 0, 1'b1, "R8");
        idle(6);
        cycle(1'b1, 1, 2, 1'b0, "R8");
        cycle(1'b1, 0, 1, 1'b0, "R8");
        // R9: back-to-back violations pulse per command
        cycle(1'b1, 1, 1, 1'b1, "R9");
        cycle(1'b1, 0, 2, 1'b0, "R9");
        cycle(1'b1, 0, 3, 1'b0, "R9");
        idle(3);
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule